// File: doc/BRIEF.md
# Five-Channel Timer Output Compare Unit

This block is a timer peripheral built around a free-running 16-bit counter and five 16-bit compare channels. On every clock, each channel tests its stored value against the counter. When a channel matches, it latches a per-channel event flag and can request an interrupt. It also drives an action onto the compare pins.

Channel 1 is the master channel. On a match it forces any subset of the five pins to programmed levels, using a mask byte and a level byte. Channels 2 to 5 each own one pin, and each applies a two-bit action code to that pin. Software reaches the counter, the compare values, the flags, the enables, the master mask and level, and the action codes through a byte-wide register port. A 16-bit value can be read coherently by reading its high byte first.

The coherent read path is a two-state machine. In IDLE no snapshot is held. A high-byte read of any 16-bit register takes the CAPTURE transition to HELD: the low byte of that register is saved, together with its address. In HELD, a further high-byte read takes RECAPTURE, which stays in HELD with a fresh snapshot. A read of the saved low-byte address takes RELEASE back to IDLE. That read returns the snapshot.

Top module: `toc_unit`

## Requirements
- R1: The counter resets to 0 and increments by one on every clock. Its high byte reads at address 0 and its low byte at address 1. Writes to those two addresses have no effect.
- R2: Channel k (k = 1..5) has its compare high byte at address 2k and its low byte at address 2k+1. Every compare value resets to 0xFFFF and reads back whatever was last written, so an idle channel works as plain storage.
- R3: When the counter equals channel k's compare value in a cycle, flag bit k-1 of the flag register (address 15) is 1 from the next cycle on. Writing 1 to a flag bit clears it, and writing 0 has no effect. If a clear and a match fall in the same cycle, the flag ends up set.
- R4: `irq` is high exactly when some flag bit is set and the same bit is set in the interrupt enable register (address 16).
- R5: The action register (address 14) holds a two-bit code for each of channels 2 to 5: channel 2 in bits 1:0, channel 3 in bits 3:2, channel 4 in bits 5:4 and channel 5 in bits 7:6. The codes mean 00 no change, 01 toggle, 10 drive low and 11 drive high. On a match of channel k, pin `oc_pin[k-1]` takes the result in the next cycle.
- R6: The action of channels 2 to 5 is applied on every match, even when the channel's flag is still set from an earlier match.
- R7: On a channel 1 match, every pin whose bit is 1 in the master mask register (address 12) takes the matching bit of the master level register (address 13). Pins whose mask bit is 0 are left to the other channels.
- R8: The master mask and master level registers store bits 4:0 only. Bits 7:5 always read as 0.
- R9: If channel 1 and a channel k match in the same cycle, and channel 1's mask covers pin k-1, the master level decides that pin.
- R10: A write to a channel's compare high byte suppresses that channel's compare in the following cycle. A match in that cycle sets no flag and moves no pin.
- R11: A read strobe on the high byte of the counter or of a compare register saves that register's low byte. The next read of the same low-byte address returns the saved byte. A low-byte read with no preceding high-byte read returns the live value.
- R12: All pins are 0 after reset and change only at the end of a cycle in which some channel matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (drives the coherent read machine) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| oc_pin | output | 5 | Compare output pins, pin j driven by channel j+1 and by channel 1 |

## Verification
Two kinds of event can land in the same cycle, and each collision is provoked on purpose. The first is a channel 1 match together with a channel 2..5 match on a pin that both want. The bench arms both channels with one target value and expects the master level on the masked pin and the channel action on an unmasked one. The second is a software flag clear together with a hardware flag set. The bench issues the clear in exactly the match cycle, as tracked by its own count of clocks since reset, and expects the flag to read back as 1. A third timing case writes a high compare byte one cycle before the match, then two cycles before it, and expects no effect in the first case and a normal match in the second.

// File: rtl/toc_pkg.sv
package toc_pkg;
    localparam int NCH      = 5;
    localparam int BW       = 8;
    localparam int CW       = 2 * BW;
    localparam int AW       = 5;
    localparam int ACTW     = 2 * (NCH - 1);
    localparam int CMP_BASE = 2;

    localparam logic [AW-1:0] A_CNT_HI = AW'(0);
    localparam logic [AW-1:0] A_CNT_LO = AW'(1);
    localparam logic [AW-1:0] A_MASK   = AW'(CMP_BASE + 2 * NCH);
    localparam logic [AW-1:0] A_DATA   = AW'(CMP_BASE + 2 * NCH + 1);
    localparam logic [AW-1:0] A_ACT    = AW'(CMP_BASE + 2 * NCH + 2);
    localparam logic [AW-1:0] A_FLAG   = AW'(CMP_BASE + 2 * NCH + 3);
    localparam logic [AW-1:0] A_IEN    = AW'(CMP_BASE + 2 * NCH + 4);

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    typedef enum logic {
        RH_IDLE,
        RH_HELD
    } hold_e;

    function automatic logic [AW-1:0] cmp_hi_addr(input int k);
        return AW'(CMP_BASE + 2 * k);
    endfunction

    function automatic logic [AW-1:0] cmp_lo_addr(input int k);
        return AW'(CMP_BASE + 2 * k + 1);
    endfunction
endpackage

// File: rtl/toc_counter.sv
module toc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/toc_channel.sv
module toc_channel #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   cnt,
    input  logic           wr_hi,
    input  logic           wr_lo,
    input  logic [W/2-1:0] wdata,
    output logic [W-1:0]   cmp,
    output logic           hit
);
    localparam int HB = W / 2;

    logic inhibit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp     <= '1;
            inhibit <= 1'b0;
        end else begin
            inhibit <= wr_hi;
            if (wr_hi) cmp[W-1:HB] <= wdata;
            if (wr_lo) cmp[HB-1:0] <= wdata;
        end
    end

    assign hit = (cnt == cmp) && !inhibit;
endmodule

// File: rtl/toc_pins.sv
module toc_pins import toc_pkg::*; #(
    parameter int N = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hit,
    input  logic [2*N-3:0]   act,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     level,
    output logic [N-1:0]     pins
);
    logic [N-1:0] nxt;

    always_comb begin
        nxt = pins;
        for (int k = 1; k < N; k++) begin
            if (hit[k]) begin
                unique case (act_e'(act[2*(k-1) +: 2]))
                    ACT_NONE:   nxt[k] = pins[k];
                    ACT_TOGGLE: nxt[k] = ~pins[k];
                    ACT_LOW:    nxt[k] = 1'b0;
                    ACT_HIGH:   nxt[k] = 1'b1;
                endcase
            end
        end
        if (hit[0]) nxt = (nxt & ~mask) | (level & mask);
    end

    always_ff @(posedge clk) begin
        if (rst) pins <= '0;
        else     pins <= nxt;
    end
endmodule

// File: rtl/toc_rdhold.sv
module toc_rdhold import toc_pkg::*; #(
    parameter int AWID = 5,
    parameter int BWID = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd,
    input  logic            is_hi,
    input  logic [AWID-1:0] addr,
    input  logic [BWID-1:0] lo_byte,
    output logic            hold_hit,
    output logic [BWID-1:0] held_byte
);
    hold_e           st, st_n;
    logic [AWID-1:0] held_addr;

    always_ff @(posedge clk) begin
        if (rst) st <= RH_IDLE;
        else     st <= st_n;
    end

    always_comb begin
        st_n     = st;
        hold_hit = 1'b0;
        unique case (st)
            RH_IDLE: begin
                if (rd && is_hi) st_n = RH_HELD;
            end
            RH_HELD: begin
                hold_hit = (addr == held_addr);
                if (rd && is_hi)                  st_n = RH_HELD;
                else if (rd && addr == held_addr) st_n = RH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr <= '0;
            held_byte <= '0;
        end else if (rd && is_hi) begin
            held_addr <= addr + 1'b1;
            held_byte <= lo_byte;
        end
    end
endmodule

// File: rtl/toc_unit.sv
module toc_unit import toc_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          irq,
    output logic [NCH-1:0] oc_pin
);
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cmp_q [NCH];
    logic [NCH-1:0]  hit_vec, wr_hi, wr_lo;
    logic [NCH-1:0]  flag_q, ien_q, mask_q, data_q, pins_q, flag_clr;
    logic [ACTW-1:0] act_q;
    logic            wide_hi, hold_hit;
    logic [BW-1:0]   wide_lo, held_byte, rd_mux;

    toc_counter #(.W(CW)) u_cnt (.clk(clk), .rst(rst), .cnt(cnt));

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign wr_hi[k] = bus_wr && (bus_addr == cmp_hi_addr(k));
        assign wr_lo[k] = bus_wr && (bus_addr == cmp_lo_addr(k));
        toc_channel #(.W(CW)) u_ch (
            .clk(clk), .rst(rst), .cnt(cnt),
            .wr_hi(wr_hi[k]), .wr_lo(wr_lo[k]), .wdata(bus_wdata),
            .cmp(cmp_q[k]), .hit(hit_vec[k])
        );
    end

    assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            data_q <= '0;
            act_q  <= '0;
            ien_q  <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NCH-1:0];
            if (bus_wr && bus_addr == A_DATA) data_q <= bus_wdata[NCH-1:0];
            if (bus_wr && bus_addr == A_ACT)  act_q  <= bus_wdata[ACTW-1:0];
            if (bus_wr && bus_addr == A_IEN)  ien_q  <= bus_wdata[NCH-1:0];
            flag_q <= (flag_q & ~flag_clr) | hit_vec;
        end
    end

    toc_pins #(.N(NCH)) u_pins (
        .clk(clk), .rst(rst), .hit(hit_vec), .act(act_q),
        .mask(mask_q), .level(data_q), .pins(pins_q)
    );

    always_comb begin
        wide_hi = (bus_addr == A_CNT_HI);
        wide_lo = cnt[BW-1:0];
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == cmp_hi_addr(k)) begin
                wide_hi = 1'b1;
                wide_lo = cmp_q[k][BW-1:0];
            end
        end
    end

    toc_rdhold #(.AWID(AW), .BWID(BW)) u_hold (
        .clk(clk), .rst(rst), .rd(bus_rd), .is_hi(wide_hi), .addr(bus_addr),
        .lo_byte(wide_lo), .hold_hit(hold_hit), .held_byte(held_byte)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CNT_HI: rd_mux = cnt[CW-1:BW];
            A_CNT_LO: rd_mux = cnt[BW-1:0];
            A_MASK:   rd_mux = BW'(mask_q);
            A_DATA:   rd_mux = BW'(data_q);
            A_ACT:    rd_mux = BW'(act_q);
            A_FLAG:   rd_mux = BW'(flag_q);
            A_IEN:    rd_mux = BW'(ien_q);
            default:  rd_mux = '0;
        endcase
        for (int k = 0; k < NCH; k++) begin
            if (bus_addr == cmp_hi_addr(k)) rd_mux = cmp_q[k][CW-1:BW];
            if (bus_addr == cmp_lo_addr(k)) rd_mux = cmp_q[k][BW-1:0];
        end
        if (hold_hit) rd_mux = held_byte;
    end

    assign bus_rdata = rd_mux;
    assign irq       = |(flag_q & ien_q);
    assign oc_pin    = pins_q;
endmodule

// File: rtl/toc_unit_chk.sv
module toc_unit_chk import toc_pkg::*; (
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] hit_vec,
    input logic [NCH-1:0] flag_q,
    input logic [NCH-1:0] ien_q,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] data_q,
    input logic [NCH-1:0] pins_q,
    input logic           irq
);
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |=> ((flag_q & $past(hit_vec)) == $past(hit_vec)));

    // R3
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_FLAG) |=> (($past(flag_q) & ~flag_q) == '0));

    // R4
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    // R7
    master_pin_chk: assert property (@(posedge clk) disable iff (rst)
        hit_vec[0] |=> ((pins_q & $past(mask_q)) == ($past(data_q) & $past(mask_q))));

    // R12
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec == '0) |=> $stable(pins_q));

    for (genvar k = 0; k < NCH; k++) begin : g_inh
        // R10
        inhibit_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == cmp_hi_addr(k)) |=> !hit_vec[k]);
    end
endmodule

bind toc_unit toc_unit_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .hit_vec(hit_vec), .flag_q(flag_q), .ien_q(ien_q), .mask_q(mask_q),
    .data_q(data_q), .pins_q(pins_q), .irq(irq)
);

// File: tb/toc_unit_tb_top.sv
module toc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] AD_CNT_HI = 5'd0;
    localparam logic [4:0] AD_CNT_LO = 5'd1;
    localparam logic [4:0] AD_MASK   = 5'd12;
    localparam logic [4:0] AD_DATA   = 5'd13;
    localparam logic [4:0] AD_ACT    = 5'd14;
    localparam logic [4:0] AD_FLAG   = 5'd15;
    localparam logic [4:0] AD_IEN    = 5'd16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [4:0] oc_pin;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [15:0] mcnt;

    toc_unit dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .oc_pin(oc_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // clocks since reset: the counter value expected in each cycle (R1)
    always @(posedge clk) begin
        if (rst) mcnt <= '0;
        else     mcnt <= mcnt + 16'd1;
    end

    function automatic logic [4:0] hi_ad(input int ch);
        return 5'(2 + 2 * ch);
    endfunction
    function automatic logic [4:0] lo_ad(input int ch);
        return 5'(3 + 2 * ch);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at count %0d", req, act, exp, mcnt);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arm(input int ch, input logic [15:0] t);
        wr(hi_ad(ch), t[15:8]);
        wr(lo_ad(ch), t[7:0]);
    endtask

    task automatic wait_until(input logic [15:0] v);
        while (mcnt != v) @(negedge clk);
    endtask

    task automatic wait_past(input logic [15:0] t);
        wait_until(t + 16'd1);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0]  b, h, l;
        logic [15:0] m, t;
        logic [4:0]  mpins, p, d, e;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R12 pins after reset", oc_pin, 0);
        check("R4 irq after reset", irq, 0);
        rd(AD_FLAG, b);  check("R3 flags after reset", b, 0);
        rd(hi_ad(2), b); check("R2 compare hi reset", b, 8'hFF);
        rd(lo_ad(2), b); check("R2 compare lo reset", b, 8'hFF);
        rd(AD_MASK, b);  check("R8 mask after reset", b, 0);

        // R1 counter and ignored writes
        m = mcnt; rd(AD_CNT_LO, b); check("R1 counter low live", b, m[7:0]);
        wr(AD_CNT_HI, 8'h00); wr(AD_CNT_LO, 8'h00);
        m = mcnt; rd(AD_CNT_HI, h); rd(AD_CNT_LO, l);
        check("R1 counter after write", {h, l}, m);

        // R11 coherent and plain reads
        repeat (3) @(negedge clk);
        m = mcnt; rd(AD_CNT_HI, h); rd(AD_CNT_LO, l);
        check("R11 held low byte", l, m[7:0]);
        check("R11 high byte", h, m[15:8]);
        m = mcnt; rd(AD_CNT_LO, b); check("R11 plain low read", b, m[7:0]);

        // R2 storage on channel 5 (low first keeps partial values in the past)
        wr(lo_ad(4), 8'hA5); wr(hi_ad(4), 8'h5A);
        rd(hi_ad(4), h); rd(lo_ad(4), l);
        check("R2 storage", {h, l}, 16'h5AA5);

        // R5 sweep of every code on every single-pin channel
        mpins = '0;
        for (int ch = 1; ch < 5; ch++) begin
            for (int code = 0; code < 4; code++) begin
                wr(AD_ACT, 8'(code << (2 * (ch - 1))));
                t = mcnt + 16'd5;
                arm(ch, t);
                wait_past(t);
                case (code)
                    1: mpins[ch] = ~mpins[ch];
                    2: mpins[ch] = 1'b0;
                    3: mpins[ch] = 1'b1;
                    default: ;
                endcase
                check("R5 action code", oc_pin, mpins);
                rd(AD_FLAG, b); check("R3 flag set", b[ch], 1);
            end
        end

        // R6 toggles on every match while flags stay set
        wr(AD_ACT, 8'h55);
        for (int rep = 0; rep < 2; rep++) begin
            t = mcnt + 16'd10;
            for (int ch = 1; ch < 5; ch++) arm(ch, t);
            wait_past(t);
            mpins[4:1] = ~mpins[4:1];
            check("R6 toggle with flag set", oc_pin, mpins);
        end

        // R3 clear semantics
        wr(AD_FLAG, 8'h00); rd(AD_FLAG, b); check("R3 write zero", b, 8'h1E);
        wr(AD_FLAG, 8'h02); rd(AD_FLAG, b); check("R3 clear one bit", b, 8'h1C);
        wr(AD_FLAG, 8'hFF); rd(AD_FLAG, b); check("R3 clear all", b, 8'h00);

        // R4 interrupt gating
        wr(AD_ACT, 8'h00);
        wr(AD_IEN, 8'h1F);
        check("R4 enabled no flag", irq, 0);
        t = mcnt + 16'd4; arm(2, t); wait_past(t);
        check("R4 irq on match", irq, 1);
        wr(AD_IEN, 8'h00); check("R4 disabled", irq, 0);
        wr(AD_IEN, 8'h04); check("R4 own bit", irq, 1);
        wr(AD_IEN, 8'h08); check("R4 other bit", irq, 0);
        wr(AD_IEN, 8'h04); wr(AD_FLAG, 8'h04); check("R4 after clear", irq, 0);

        // R3 clear in the match cycle: set wins
        t = mcnt + 16'd5; arm(3, t);
        wait_until(t);
        wr(AD_FLAG, 8'h08);
        rd(AD_FLAG, b); check("R3 set beats clear", b[3], 1);
        wr(AD_FLAG, 8'hFF);

        // R10 high-byte write one cycle before match suppresses it
        wr(AD_ACT, 8'h01);
        t = mcnt + 16'd6;
        wr(lo_ad(1), t[7:0]);
        wait_until(t - 16'd1);
        wr(hi_ad(1), t[15:8]);
        wait_past(t);
        rd(AD_FLAG, b); check("R10 inhibited flag", b[1], 0);
        check("R10 inhibited pin", oc_pin, mpins);
        t = mcnt + 16'd6;
        wr(lo_ad(1), t[7:0]);
        wait_until(t - 16'd2);
        wr(hi_ad(1), t[15:8]);
        wait_past(t);
        rd(AD_FLAG, b); check("R10 control flag", b[1], 1);
        mpins[1] = ~mpins[1];
        check("R10 control pin", oc_pin, mpins);

        // R7 / R8 sweep of every master mask
        wr(AD_ACT, 8'h00);
        for (int mk = 0; mk < 32; mk++) begin
            p = 5'(mk * 3 + 7);
            d = 5'(~mk) ^ 5'(mk >> 1);
            wr(AD_MASK, 8'hFF);
            wr(AD_DATA, {3'b111, p});
            t = mcnt + 16'd4; arm(0, t); wait_past(t);
            check("R7 full mask prime", oc_pin, p);
            wr(AD_MASK, {3'b111, 5'(mk)});
            wr(AD_DATA, {3'b101, d});
            rd(AD_MASK, b); check("R8 mask readback", b, 8'(mk));
            rd(AD_DATA, b); check("R8 level readback", b, {3'b000, d});
            t = mcnt + 16'd4; arm(0, t); wait_past(t);
            e = (p & ~5'(mk)) | (d & 5'(mk));
            check("R7 masked update", oc_pin, e);
        end

        // R9 master channel wins a shared pin
        wr(AD_MASK, 8'h1F); wr(AD_DATA, 8'h00);
        t = mcnt + 16'd4; arm(0, t); wait_past(t);
        wr(AD_FLAG, 8'hFF);
        wr(AD_ACT, 8'h3C);
        wr(AD_MASK, 8'h04); wr(AD_DATA, 8'h00);
        t = mcnt + 16'd10;
        arm(0, t); arm(2, t); arm(3, t);
        wait_past(t);
        check("R9 shared pin", oc_pin, 5'b01000);
        rd(AD_FLAG, b); check("R3 joint flags", b, 8'h0D);

        report();
    end
endmodule